// File: doc/BRIEF.md
# Serial Synthesizer Programming Loader

This block receives configuration words for a frequency-synthesizer control core over three pins: a serial data line, a serial clock and a latch-enable strobe. All three pins are brought into the system clock domain through a short synchronizer. Each rising serial clock edge shifts one data bit into a 21-bit word register. The most significant bit arrives first. When the strobe rises, the two most recently shifted bits choose which holding register receives the other nineteen bits.

There are three holding registers. The feedback divider register holds the fast-lock GO bit, a 13-bit B count and a 5-bit A count. The reference divider register holds the lock-detect precision bit and a 14-bit divide ratio. The function register holds nineteen raw function bits. Before a word is stored, it is checked against the divider rules. A word that breaks them is refused and an error flag is raised. The flag clears when the next word is accepted.

Top module: `synth_serial_loader`

## Requirements
- R1: After the active-low asynchronous reset, every latched output and `word_err` are zero.
- R2: Bits are shifted in most significant bit first. Only the last 21 bits clocked before the strobe rises count; any earlier bits have already been pushed out.
- R3: A word whose last two bits are 1 then 0 goes to the feedback register. In shifted order it carries GO (first bit), then B (13 bits, MSB first), then A (5 bits, MSB first).
- R4: A word ending in 0 then 0 goes to the reference register. In shifted order it carries the precision bit, then 4 test bits, then the 14-bit divide ratio (MSB first).
- R5: A word ending in 0 then 1 copies its first 19 shifted bits into `func_bits`. The first bit lands in bit 18 of `func_bits`.
- R6: Holding registers change only after a rising edge of the latch-enable strobe. A shift with no strobe changes nothing. Registers that the word does not select keep their values.
- R7: A feedback word with B < A or B < 3 leaves the feedback register unchanged and sets `word_err` to 1.
- R8: A reference word with any test bit set to 1 leaves the reference register unchanged and sets `word_err` to 1.
- R9: Any accepted word, of any of the three kinds, clears `word_err` to 0.
- R10: A word ending in 1 then 1 changes no register and leaves `word_err` as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock pin |
| ser_data | input | 1 | Serial data pin |
| ser_le | input | 1 | Latch-enable strobe pin |
| a_cnt | output | 5 | Latched A count |
| b_cnt | output | 13 | Latched B count |
| go_bit | output | 1 | Latched fast-lock GO bit |
| r_div | output | 14 | Latched reference divide ratio |
| ld_prec | output | 1 | Latched lock-detect precision bit |
| func_bits | output | 19 | Latched function bits |
| word_err | output | 1 | Last decoded word was refused |

## Verification
The hardest case to reach is a refused word that arrives after several different kinds of accepted word. Reaching it checks that the refusal leaves every holding register exactly as it was and that only the flag moves. The random stimulus covers this by sending a long mix of the three word kinds. It deliberately builds feedback words with small or inverted B counts and reference words with test bits set, so refusals land on varied stored state. Directed words cover the remaining cases: a strobe preceded by extra bits, a full shift with no strobe, and the unused control code.

// File: rtl/synth_serial_loader.sv
module synth_serial_loader #(
  parameter int SYNC_STAGES = 2,
  parameter int B_MIN       = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [4:0]  a_cnt,
  output logic [12:0] b_cnt,
  output logic        go_bit,
  output logic [13:0] r_div,
  output logic        ld_prec,
  output logic [18:0] func_bits,
  output logic        word_err
);
  localparam int WORD_W = 21;
  localparam int TOP    = SYNC_STAGES - 1;

  logic [TOP:0] clk_s, dat_s, le_s;
  logic clk_d, le_d;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s <= '0;
      dat_s <= '0;
      le_s  <= '0;
      clk_d <= 1'b0;
      le_d  <= 1'b0;
    end else begin
      clk_s[0] <= ser_clk;
      dat_s[0] <= ser_data;
      le_s[0]  <= ser_le;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        clk_s[i] <= clk_s[i-1];
        dat_s[i] <= dat_s[i-1];
        le_s[i]  <= le_s[i-1];
      end
      clk_d <= clk_s[TOP];
      le_d  <= le_s[TOP];
    end
  end

  wire sclk_rise = clk_s[TOP] & ~clk_d;
  wire le_rise   = le_s[TOP] & ~le_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (sclk_rise) sr <= {sr[WORD_W-2:0], dat_s[TOP]};
  end

  wire [1:0]  ctl    = sr[1:0];
  wire [12:0] nb     = sr[19:7];
  wire [4:0]  na     = sr[6:2];
  wire        is_n   = (ctl == 2'b10);
  wire        is_r   = (ctl == 2'b00);
  wire        is_f   = (ctl == 2'b01);
  wire        n_ok   = (nb >= {8'd0, na}) && (nb >= 13'(B_MIN));
  wire        r_ok   = (sr[19:16] == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cnt     <= '0;
      b_cnt     <= '0;
      go_bit    <= 1'b0;
      r_div     <= '0;
      ld_prec   <= 1'b0;
      func_bits <= '0;
      word_err  <= 1'b0;
    end else if (le_rise) begin
      if (is_n) begin
        word_err <= !n_ok;
        if (n_ok) begin
          go_bit <= sr[20];
          b_cnt  <= nb;
          a_cnt  <= na;
        end
      end else if (is_r) begin
        word_err <= !r_ok;
        if (r_ok) begin
          ld_prec <= sr[20];
          r_div   <= sr[15:2];
        end
      end else if (is_f) begin
        word_err  <= 1'b0;
        func_bits <= sr[20:2];
      end
    end
  end
endmodule

// File: rtl/synth_serial_loader_chk.sv
module synth_serial_loader_chk #(
  parameter int B_MIN = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        le_rise,
  input logic [4:0]  a_cnt,
  input logic [12:0] b_cnt,
  input logic        go_bit,
  input logic [13:0] r_div,
  input logic        ld_prec,
  input logic [18:0] func_bits,
  input logic        word_err
);
  always_comb begin
    if (!rst_n)
      a_r1_reset_zero: assert (a_cnt == '0 && b_cnt == '0 && r_div == '0 && func_bits == '0 && !word_err);
  end

  a_r6_n_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(le_rise) |-> ($stable(a_cnt) && $stable(b_cnt) && $stable(go_bit)));

  a_r6_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(le_rise) |-> ($stable(r_div) && $stable(ld_prec)));

  a_r6_f_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(le_rise) |-> $stable(func_bits));

  a_r7_n_rules: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(a_cnt) || !$stable(b_cnt)) |-> (b_cnt >= {8'd0, a_cnt} && b_cnt >= 13'(B_MIN)));

  a_r9_err_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_err) |-> $past(le_rise));
endmodule

bind synth_serial_loader synth_serial_loader_chk #(.B_MIN(B_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .le_rise(le_rise),
  .a_cnt(a_cnt), .b_cnt(b_cnt), .go_bit(go_bit),
  .r_div(r_div), .ld_prec(ld_prec), .func_bits(func_bits), .word_err(word_err)
);

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [4:0]  a_cnt;
  logic [12:0] b_cnt;
  logic        go_bit;
  logic [13:0] r_div;
  logic        ld_prec;
  logic [18:0] func_bits;
  logic        word_err;

  int n_tests = 0, n_fail = 0;
  logic [4:0]  e_a;
  logic [12:0] e_b;
  logic        e_go;
  logic [13:0] e_r;
  logic        e_ld;
  logic [18:0] e_f;
  logic        e_err;

  always #5 clk = ~clk;

  synth_serial_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .a_cnt(a_cnt), .b_cnt(b_cnt), .go_bit(go_bit), .r_div(r_div), .ld_prec(ld_prec),
    .func_bits(func_bits), .word_err(word_err)
  );

  function automatic void model(input logic [20:0] w);
    case (w[1:0])
      2'b10: begin
        if (w[19:7] >= {8'd0, w[6:2]} && w[19:7] >= 13'd3) begin
          e_go = w[20]; e_b = w[19:7]; e_a = w[6:2]; e_err = 1'b0;
        end else e_err = 1'b1;
      end
      2'b00: begin
        if (w[19:16] == 4'd0) begin
          e_ld = w[20]; e_r = w[15:2]; e_err = 1'b0;
        end else e_err = 1'b1;
      end
      2'b01: begin e_f = w[20:2]; e_err = 1'b0; end
      default: ;
    endcase
  endfunction

  function automatic logic [20:0] n_word(input logic g, input logic [12:0] b, input logic [4:0] a);
    return {g, b, a, 2'b10};
  endfunction

  function automatic logic [20:0] r_word(input logic p, input logic [3:0] t, input logic [13:0] r);
    return {p, t, r, 2'b00};
  endfunction

  task automatic check(input string req);
    n_tests++;
    if ({a_cnt, b_cnt, go_bit, r_div, ld_prec, func_bits, word_err} !==
        {e_a, e_b, e_go, e_r, e_ld, e_f, e_err}) begin
      n_fail++;
      $display("FAIL %s: got a=%0d b=%0d go=%0b r=%0d ld=%0b f=%h err=%0b exp a=%0d b=%0d go=%0b r=%0d ld=%0b f=%h err=%0b",
               req, a_cnt, b_cnt, go_bit, r_div, ld_prec, func_bits, word_err,
               e_a, e_b, e_go, e_r, e_ld, e_f, e_err);
    end
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    repeat (5) @(negedge clk);
    ser_le = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic send(input logic [20:0] w, input string req);
    shift_bits({43'd0, w}, 21);
    strobe();
    model(w);
    check(req);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [20:0] w;
    void'($urandom(32'd1234));
    {e_a, e_b, e_go, e_r, e_ld, e_f, e_err} = '0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release");

    send(n_word(1'b1, 13'd301, 5'd19), "R3 feedback decode");
    send(r_word(1'b1, 4'd0, 14'd9001), "R4 reference decode");
    send({19'h5A3C1, 2'b01}, "R5 function decode");
    send(n_word(1'b0, 13'd2, 5'd0), "R7 B below 3");
    send({19'h12345, 2'b01}, "R9 clear after function word");
    send(n_word(1'b1, 13'd10, 5'd11), "R7 B below A");
    send(n_word(1'b0, 13'd3, 5'd3), "R9 boundary B=A=3 accepted");
    send(r_word(1'b0, 4'd8, 14'd77), "R8 test bit set");
    send({19'h7FFFF, 2'b11}, "R10 unused code keeps error");
    send(r_word(1'b0, 4'd0, 14'd16383), "R9 reference accepted");

    w = n_word(1'b1, 13'd4095, 5'd31);
    shift_bits({43'd0, w}, 21);
    repeat (5) @(negedge clk);
    check("R6 no strobe no change");
    strobe();
    model(w);
    check("R6 late strobe");

    w = r_word(1'b1, 4'd0, 14'd555);
    shift_bits({39'd0, 4'b1011, w}, 25);
    strobe();
    model(w);
    check("R2 extra leading bits pushed out");

    for (int k = 0; k < 200; k++) begin
      int kind = int'($urandom % 4);
      case (kind)
        0: begin
          logic [12:0] b = 13'($urandom);
          logic [4:0]  a = 5'($urandom);
          if ($urandom % 4 == 0) b = 13'($urandom % 6);
          send(n_word(1'($urandom), b, a), "R3 R7 random feedback");
        end
        1: begin
          logic [3:0] t = ($urandom % 5 == 0) ? 4'($urandom) : 4'd0;
          send(r_word(1'($urandom), t, 14'($urandom)), "R4 R8 random reference");
        end
        2: send({19'($urandom), 2'b01}, "R5 R6 random function");
        default: send({19'($urandom), 2'b11}, "R10 random unused");
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule